// File: doc/BRIEF.md
# SDRAM Command Spacing Guard

The guard sits between an SDRAM command scheduler and the memory command bus. Each cycle it tells the scheduler whether an ACTIVE, READ, WRITE, PRECHARGE or REFRESH command to the bank on `cmd_bank` may go out now. It bases this on minimum spacings held in a 32-bit timing word. It keeps an open or closed flag per bank, an activation timer per bank, and one shared window that follows every read or write burst. Two further timers follow precharge and refresh. It also raises a data-capture strobe once the programmed read latency has passed after a READ. In DDR mode that latency is counted in half periods of the bus clock, and a flag marks a capture that falls on the second half.

The scheduler samples the permits combinationally and issues a command by raising `cmd_valid` with the opcode. The guard always tracks an issued command. If that command went out while its permit was low, the guard counts a violation and sets a sticky error flag. The timing word is loaded with `cfg_wr`. A load that arrives while any timer or pending capture is still running is discarded. `ddr_mode` is a static pin that selects how the latency code is read.

Top module: `sdram_cmd_guard`

## Requirements
- R1: After reset every timing field is zero, all banks are closed, no strobe is pending, the violation count is 0 and the sticky flag is clear. With the all-zero word, READ is permitted on the cycle right after ACTIVE, and ACTIVE is permitted on the cycle right after PRECHARGE.
- R2: Timing word bits [31:28] hold the read gap G. After a READ in cycle t, `perm_rd`, `perm_wr` and `perm_pre` are low in cycles t+1 to t+G-1. A gap of 0 or 1 blocks nothing.
- R3: Bits [27:24] hold the write gap G. After a WRITE in cycle t, READ, WRITE and PRECHARGE are blocked in cycles t+1 to t+G-1. A later READ or WRITE reloads the same shared window.
- R4: Bits [18:16] hold the activation field N. After ACTIVE to bank b in cycle t, READ and WRITE to bank b are blocked in cycles t+1 to t+N, which gives a spacing of N+1 cycles. READ and WRITE also need bank b to be open.
- R5: Bits [14:11] hold the precharge gap P and bits [10:7] the refresh gap F. After PRECHARGE in cycle t, ACTIVE and REFRESH are blocked in cycles t+1 to t+P-1. After REFRESH, both are blocked in cycles t+1 to t+F-1.
- R6: ACTIVE requires its bank to be closed. REFRESH requires all banks to be closed. ACTIVE opens its bank and PRECHARGE closes it. Opcodes: 0 ACTIVE, 1 READ, 2 WRITE, 3 PRECHARGE, 4 REFRESH. Codes 5 to 7 have no effect.
- R7: Bits [23:20] hold the latency code C. After a READ in cycle t, `cap_strobe` is high in cycle t+L, where L = C in SDR mode and L = C/2 (rounded down) in DDR mode. L = 0 gives no strobe. `cap_half` is high with the strobe when DDR mode is selected and C is odd.
- R8: `cfg_err` is high while SDR mode is selected and the stored latency code is 6 or 7.
- R9: A command with opcode 0 to 4 that issues while its permit is low increments `viol_count` on the next cycle. The count saturates at its maximum. Such a command also sets `viol_sticky`, which only reset clears.
- R10: A `cfg_wr` takes effect on the next cycle only when no timer is nonzero and no capture is pending. Otherwise the word is dropped and the old spacings stay in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ddr_mode | input | 1 | 1 selects DDR interpretation of the latency code |
| cfg_wr | input | 1 | Load request for the timing word |
| cfg_word | input | 32 | Timing word |
| cmd_valid | input | 1 | A command issues this cycle |
| cmd_op | input | 3 | Command opcode |
| cmd_bank | input | BANK_W | Bank of the command and of the permit query |
| perm_act | output | 1 | ACTIVE to cmd_bank allowed now |
| perm_rd | output | 1 | READ to cmd_bank allowed now |
| perm_wr | output | 1 | WRITE to cmd_bank allowed now |
| perm_pre | output | 1 | PRECHARGE allowed now |
| perm_ref | output | 1 | REFRESH allowed now |
| cap_strobe | output | 1 | Read data capture due this cycle |
| cap_half | output | 1 | Capture falls on the second half-period |
| cfg_err | output | 1 | Latency code illegal for SDR mode |
| viol_sticky | output | 1 | A violation has occurred since reset |
| viol_count | output | VIOL_W | Saturating violation count |

## Verification
The permits and `cfg_err` follow the current inputs and state within the same cycle. Blocking set up by a command first shows in the cycle after that command, a stored timing word acts from the cycle after its load, and the violation count moves one cycle after the offending command. The capture strobe is due exactly L cycles after its READ. The bench therefore drives every input just after the falling edge, compares all outputs one time unit later against a cycle-counted model, and advances that model only at the rising edge that registers the same inputs. Directed sequences count cycles from each command and check the first blocked cycle, the last blocked cycle and the first permitted one.

// File: rtl/sgd_pkg.sv
package sgd_pkg;

  localparam int CFG_W  = 32;
  localparam int GAP_W  = 4;
  localparam int ACT_W  = 3;

  typedef enum logic [2:0] {
    OP_ACT = 3'd0,
    OP_RD  = 3'd1,
    OP_WR  = 3'd2,
    OP_PRE = 3'd3,
    OP_REF = 3'd4
  } cmd_op_e;

  typedef struct packed {
    logic [GAP_W-1:0] rd_gap;
    logic [GAP_W-1:0] wr_gap;
    logic [GAP_W-1:0] cas_code;
    logic [ACT_W-1:0] act_gap;
    logic [GAP_W-1:0] pch_gap;
    logic [GAP_W-1:0] rfr_gap;
  } gap_cfg_t;

  // spacing of G cycles means G-1 blocked cycles after the command
  function automatic logic [GAP_W-1:0] gap_load(input logic [GAP_W-1:0] g);
    return (g == '0) ? '0 : g - 1'b1;
  endfunction

endpackage

// File: rtl/sgd_down_cnt.sv
module sgd_down_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_nxt;
  logic         cnt_en;

  always_comb begin
    cnt_en  = load | (cnt_q != '0);
    cnt_nxt = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nxt;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/sgd_cfg_reg.sv
module sgd_cfg_reg
  import sgd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_req,
  input  logic             busy,
  input  logic [CFG_W-1:0] word,
  output gap_cfg_t         cfg
);

  gap_cfg_t cfg_q;
  gap_cfg_t cfg_nxt;
  logic     cfg_en;
  logic     unused_word_bits;

  assign unused_word_bits = ^{word[19], word[15], word[6:0]};

  always_comb begin
    cfg_en           = wr_req & ~busy;
    cfg_nxt.rd_gap   = word[31:28];
    cfg_nxt.wr_gap   = word[27:24];
    cfg_nxt.cas_code = word[23:20];
    cfg_nxt.act_gap  = word[18:16];
    cfg_nxt.pch_gap  = word[14:11];
    cfg_nxt.rfr_gap  = word[10:7];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_en) cfg_q <= cfg_nxt;
  end

  assign cfg = cfg_q;

endmodule

// File: rtl/sgd_bank_track.sv
module sgd_bank_track #(
  parameter int NB = 4,
  parameter int BW = 2,
  parameter int W  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act_hit,
  input  logic          pre_hit,
  input  logic [BW-1:0] bank,
  input  logic [W-1:0]  act_load,
  output logic [NB-1:0] open_vec,
  output logic [NB-1:0] ready_vec
);

  logic [NB-1:0] open_q;
  logic [NB-1:0] open_nxt;
  logic          open_en;

  always_comb begin
    open_en  = act_hit | pre_hit;
    open_nxt = open_q;
    for (int b = 0; b < NB; b++) begin
      if (bank == BW'(b)) begin
        if (act_hit)      open_nxt[b] = 1'b1;
        else if (pre_hit) open_nxt[b] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       open_q <= '0;
    else if (open_en) open_q <= open_nxt;
  end

  assign open_vec = open_q;

  for (genvar gb = 0; gb < NB; gb++) begin : g_bank
    sgd_down_cnt #(.W(W)) u_act_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (act_hit && (bank == BW'(gb))),
      .load_val (act_load),
      .zero     (ready_vec[gb])
    );
  end

endmodule

// File: rtl/sgd_cap_pipe.sv
module sgd_cap_pipe #(
  parameter int DEPTH = 16,
  parameter int LW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic [LW-1:0] lat,
  output logic          strobe,
  output logic          busy
);

  logic [DEPTH-1:0] sr_q;
  logic [DEPTH-1:0] sr_nxt;
  logic             sr_en;

  always_comb begin
    sr_en  = fire | (sr_q != '0);
    sr_nxt = sr_q >> 1;
    if (fire && (lat != '0)) sr_nxt[lat - 1'b1] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr_q <= '0;
    else if (sr_en) sr_q <= sr_nxt;
  end

  assign strobe = sr_q[0];
  assign busy   = (sr_q != '0);

endmodule

// File: rtl/sdram_cmd_guard.sv
module sdram_cmd_guard
  import sgd_pkg::*;
#(
  parameter  int NUM_BANKS = 4,
  parameter  int VIOL_W    = 8,
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ddr_mode,
  input  logic              cfg_wr,
  input  logic [31:0]       cfg_word,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [BANK_W-1:0] cmd_bank,
  output logic              perm_act,
  output logic              perm_rd,
  output logic              perm_wr,
  output logic              perm_pre,
  output logic              perm_ref,
  output logic              cap_strobe,
  output logic              cap_half,
  output logic              cfg_err,
  output logic              viol_sticky,
  output logic [VIOL_W-1:0] viol_count
);

  localparam int CAP_DEPTH = 1 << GAP_W;

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  gap_cfg_t           cfg;
  logic [NUM_BANKS-1:0] open_vec;
  logic [NUM_BANKS-1:0] ready_vec;
  logic               rw_zero, pch_zero, rfr_zero, cap_busy, busy;
  logic               is_act, is_rd, is_wr, is_pre, is_ref;
  logic               cmd_legal, cmd_ok, viol;
  logic               sel_open, sel_ready;
  logic [GAP_W-1:0]   rw_load, lat;

  // ---------------- permits ----------------
  always_comb begin
    sel_open  = open_vec[cmd_bank];
    sel_ready = ready_vec[cmd_bank];
    perm_act  = ~sel_open & pch_zero & rfr_zero;
    perm_rd   = sel_open & sel_ready & rw_zero;
    perm_wr   = sel_open & sel_ready & rw_zero;
    perm_pre  = rw_zero;
    perm_ref  = ~(|open_vec) & pch_zero & rfr_zero;
  end

  // ---------------- command decode ----------------
  always_comb begin
    is_act    = cmd_valid && (cmd_op == OP_ACT);
    is_rd     = cmd_valid && (cmd_op == OP_RD);
    is_wr     = cmd_valid && (cmd_op == OP_WR);
    is_pre    = cmd_valid && (cmd_op == OP_PRE);
    is_ref    = cmd_valid && (cmd_op == OP_REF);
    cmd_legal = 1'b1;
    cmd_ok    = 1'b0;
    case (cmd_op)
      OP_ACT:  cmd_ok = perm_act;
      OP_RD:   cmd_ok = perm_rd;
      OP_WR:   cmd_ok = perm_wr;
      OP_PRE:  cmd_ok = perm_pre;
      OP_REF:  cmd_ok = perm_ref;
      default: cmd_legal = 1'b0;
    endcase
    viol    = cmd_valid & cmd_legal & ~cmd_ok;
    rw_load = is_rd ? gap_load(cfg.rd_gap) : gap_load(cfg.wr_gap);
    lat     = ddr_mode ? {1'b0, cfg.cas_code[GAP_W-1:1]} : cfg.cas_code;
    busy    = ~rw_zero | ~pch_zero | ~rfr_zero | ~(&ready_vec) | cap_busy;
  end

  // ---------------- state ----------------
  sgd_cfg_reg u_cfg (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .wr_req (cfg_wr),
    .busy   (busy),
    .word   (cfg_word),
    .cfg    (cfg)
  );

  sgd_bank_track #(.NB(NUM_BANKS), .BW(BANK_W), .W(GAP_W)) u_banks (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .act_hit   (is_act),
    .pre_hit   (is_pre),
    .bank      (cmd_bank),
    .act_load  ({1'b0, cfg.act_gap}),
    .open_vec  (open_vec),
    .ready_vec (ready_vec)
  );

  sgd_down_cnt #(.W(GAP_W)) u_rw_cnt (
    .clk (clk), .rst_n (rst_core_n),
    .load (is_rd | is_wr), .load_val (rw_load), .zero (rw_zero)
  );

  sgd_down_cnt #(.W(GAP_W)) u_pch_cnt (
    .clk (clk), .rst_n (rst_core_n),
    .load (is_pre), .load_val (gap_load(cfg.pch_gap)), .zero (pch_zero)
  );

  sgd_down_cnt #(.W(GAP_W)) u_rfr_cnt (
    .clk (clk), .rst_n (rst_core_n),
    .load (is_ref), .load_val (gap_load(cfg.rfr_gap)), .zero (rfr_zero)
  );

  sgd_cap_pipe #(.DEPTH(CAP_DEPTH), .LW(GAP_W)) u_cap (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .fire   (is_rd),
    .lat    (lat),
    .strobe (cap_strobe),
    .busy   (cap_busy)
  );

  assign cap_half = cap_strobe & ddr_mode & cfg.cas_code[0];
  assign cfg_err  = ~ddr_mode & ((cfg.cas_code == 4'd6) | (cfg.cas_code == 4'd7));

  // ---------------- violation bookkeeping ----------------
  logic [VIOL_W-1:0] vcnt_q, vcnt_nxt;
  logic              vstk_q, vstk_nxt;

  always_comb begin
    vcnt_nxt = (vcnt_q != '1) ? vcnt_q + 1'b1 : vcnt_q;
    vstk_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      vcnt_q <= '0;
      vstk_q <= 1'b0;
    end else if (viol) begin
      vcnt_q <= vcnt_nxt;
      vstk_q <= vstk_nxt;
    end
  end

  assign viol_count  = vcnt_q;
  assign viol_sticky = vstk_q;

endmodule

// File: rtl/sgd_checker.sv
module sgd_checker
  import sgd_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int VIOL_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ddr_mode,
  input logic              cfg_wr,
  input logic              cmd_valid,
  input logic [2:0]        cmd_op,
  input logic [BANK_W-1:0] cmd_bank,
  input logic              perm_act,
  input logic              perm_rd,
  input logic              perm_pre,
  input logic              perm_ref,
  input logic              cap_strobe,
  input logic              cap_half,
  input logic              cfg_err,
  input logic              viol_sticky,
  input logic [VIOL_W-1:0] viol_count,
  input gap_cfg_t          cfg,
  input logic              busy
);

  a_r2_read_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_RD && cfg.rd_gap > 4'd1) |=> !perm_pre);

  a_r3_write_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_WR && cfg.wr_gap > 4'd1) |=> !perm_pre);

  a_r4_act_blocks_rw: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_ACT && cfg.act_gap != 3'd0)
      |=> (cmd_bank != $past(cmd_bank) || !perm_rd));

  a_r5_pch_blocks_act: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_PRE && cfg.pch_gap > 4'd1) |=> !perm_act);

  a_r6_ref_implies_act: assert property (@(posedge clk) disable iff (!rst_n)
    perm_ref |-> perm_act);

  a_r7_half_needs_ddr: assert property (@(posedge clk) disable iff (!rst_n)
    cap_half |-> (cap_strobe && ddr_mode));

  a_r8_err_only_sdr: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !ddr_mode);

  a_r9_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
    viol_sticky |=> viol_sticky);

  a_r9_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_count != $past(viol_count))
      |-> (viol_count == VIOL_W'($past(viol_count) + 1'b1)));

  a_r10_busy_drops_load: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && busy) |=> $stable(cfg));

endmodule

bind sdram_cmd_guard sgd_checker #(.BANK_W(BANK_W), .VIOL_W(VIOL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_core_n),
  .ddr_mode    (ddr_mode),
  .cfg_wr      (cfg_wr),
  .cmd_valid   (cmd_valid),
  .cmd_op      (cmd_op),
  .cmd_bank    (cmd_bank),
  .perm_act    (perm_act),
  .perm_rd     (perm_rd),
  .perm_pre    (perm_pre),
  .perm_ref    (perm_ref),
  .cap_strobe  (cap_strobe),
  .cap_half    (cap_half),
  .cfg_err     (cfg_err),
  .viol_sticky (viol_sticky),
  .viol_count  (viol_count),
  .cfg         (cfg),
  .busy        (busy)
);

// File: tb/sim_sdram_cmd_guard.sv
`timescale 1ns/1ps
module sim_sdram_cmd_guard;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ddr_mode, cfg_wr, cmd_valid;
  logic [31:0] cfg_word;
  logic [2:0]  cmd_op;
  logic [1:0]  cmd_bank;
  logic        perm_act, perm_rd, perm_wr, perm_pre, perm_ref;
  logic        cap_strobe, cap_half, cfg_err, viol_sticky;
  logic [7:0]  viol_count;

  always #4 clk = ~clk;

  sdram_cmd_guard u0 (
    .clk(clk), .rst_n(rst_n), .ddr_mode(ddr_mode), .cfg_wr(cfg_wr),
    .cfg_word(cfg_word), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .perm_act(perm_act), .perm_rd(perm_rd),
    .perm_wr(perm_wr), .perm_pre(perm_pre), .perm_ref(perm_ref),
    .cap_strobe(cap_strobe), .cap_half(cap_half), .cfg_err(cfg_err),
    .viol_sticky(viol_sticky), .viol_count(viol_count)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  bit want_ddr = 0;

  // reference model
  int          m_rw, m_pch, m_rfr, m_vc;
  int          m_act [4];
  bit          m_open[4];
  bit   [15:0] m_sr;
  bit   [31:0] m_cfg;
  bit          m_err;

  function automatic int f_rd();  return int'(m_cfg[31:28]); endfunction
  function automatic int f_wr();  return int'(m_cfg[27:24]); endfunction
  function automatic int f_cas(); return int'(m_cfg[23:20]); endfunction
  function automatic int f_act(); return int'(m_cfg[18:16]); endfunction
  function automatic int f_pch(); return int'(m_cfg[14:11]); endfunction
  function automatic int f_rfr(); return int'(m_cfg[10:7]);  endfunction
  function automatic int g1(int g); return (g == 0) ? 0 : g - 1; endfunction
  function automatic int dn(int x); return (x == 0) ? 0 : x - 1; endfunction

  function automatic bit any_open();
    return m_open[0] | m_open[1] | m_open[2] | m_open[3];
  endfunction
  function automatic bit e_act(int b); return !m_open[b] && m_pch == 0 && m_rfr == 0; endfunction
  function automatic bit e_rw(int b);  return m_open[b] && m_act[b] == 0 && m_rw == 0; endfunction
  function automatic bit e_pre();      return m_rw == 0; endfunction
  function automatic bit e_ref();      return !any_open() && m_pch == 0 && m_rfr == 0; endfunction
  function automatic bit permit(int op, int b);
    case (op)
      0: return e_act(b);
      1, 2: return e_rw(b);
      3: return e_pre();
      4: return e_ref();
      default: return 1'b1;
    endcase
  endfunction

  function automatic bit [31:0] mkword(int rd, int wr, int cas, int act, int pch, int rfr);
    return (32'(rd) << 28) | (32'(wr) << 24) | (32'(cas) << 20) |
           (32'(act) << 16) | (32'(pch) << 11) | (32'(rfr) << 7);
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int b = int'(cmd_bank);
    int c = f_cas();
    chk("R5 perm_act", perm_act, e_act(b));
    chk("R2 perm_rd",  perm_rd,  e_rw(b));
    chk("R3 perm_wr",  perm_wr,  e_rw(b));
    chk("R3 perm_pre", perm_pre, e_pre());
    chk("R6 perm_ref", perm_ref, e_ref());
    chk("R7 cap_strobe", cap_strobe, m_sr[0]);
    chk("R7 cap_half", cap_half, m_sr[0] & want_ddr & c[0]);
    chk("R8 cfg_err", cfg_err, (!want_ddr && (c == 6 || c == 7)) ? 1 : 0);
    chk("R9 viol_count", viol_count, m_vc);
    chk("R9 viol_sticky", viol_sticky, m_err);
  endtask

  task automatic drive(bit v, int op, int b, bit cw, bit [31:0] w);
    @(negedge clk);
    cmd_valid = v; cmd_op = 3'(op); cmd_bank = 2'(b);
    cfg_wr = cw; cfg_word = w; ddr_mode = want_ddr;
    #1;
    compare_all();
  endtask

  task automatic tick();
    bit busy, ok;
    int op, b, lat;
    @(posedge clk);
    op = int'(cmd_op); b = int'(cmd_bank);
    busy = m_rw != 0 || m_pch != 0 || m_rfr != 0 || m_sr != 0 ||
           m_act[0] != 0 || m_act[1] != 0 || m_act[2] != 0 || m_act[3] != 0;
    ok  = permit(op, b);
    lat = ddr_mode ? (f_cas() >> 1) : f_cas();
    m_rw = dn(m_rw); m_pch = dn(m_pch); m_rfr = dn(m_rfr);
    for (int i = 0; i < 4; i++) m_act[i] = dn(m_act[i]);
    m_sr = m_sr >> 1;
    if (cmd_valid && op <= 4) begin
      if (!ok) begin
        if (m_vc < 255) m_vc++;
        m_err = 1;
      end
      case (op)
        0: begin m_open[b] = 1; m_act[b] = f_act(); end
        1: begin m_rw = g1(f_rd()); if (lat > 0) m_sr[lat-1] = 1'b1; end
        2: m_rw = g1(f_wr());
        3: begin m_open[b] = 0; m_pch = g1(f_pch()); end
        default: m_rfr = g1(f_rfr());
      endcase
    end
    if (cfg_wr && !busy) m_cfg = cfg_word;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin drive(0, 0, 0, 0, 0); tick(); end
  endtask

  task automatic cmd(int op, int b);
    drive(1, op, b, 0, 0); tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit [31:0] wa, wb;
    int seed;
    seed = int'($urandom(32'd20250611));
    m_rw = 0; m_pch = 0; m_rfr = 0; m_vc = 0; m_sr = 0; m_cfg = 0; m_err = 0;
    for (int i = 0; i < 4; i++) begin m_act[i] = 0; m_open[i] = 0; end
    rst_n = 0; ddr_mode = 0; cfg_wr = 0; cfg_word = 0;
    cmd_valid = 0; cmd_op = 0; cmd_bank = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    idle(4);

    // R1: reset state and zero spacings
    drive(0, 0, 0, 0, 0);
    chk("R1 reset perm_act", perm_act, 1);
    chk("R1 reset perm_rd closed", perm_rd, 0);
    chk("R1 reset perm_ref", perm_ref, 1);
    chk("R1 reset viol_count", viol_count, 0);
    chk("R1 reset strobe", cap_strobe, 0);
    tick();
    cmd(0, 0);
    drive(0, 0, 0, 0, 0); chk("R1 zero act gap", perm_rd, 1); tick();
    cmd(3, 0);
    drive(0, 0, 0, 0, 0); chk("R1 zero pch gap", perm_act, 1); tick();

    // load word A
    wa = mkword(3, 4, 3, 2, 3, 2);
    drive(0, 0, 0, 1, wa); tick();
    idle(2);

    // R4 / R6
    cmd(0, 0);
    drive(0, 0, 0, 0, 0); chk("R4 rd blocked t+1", perm_rd, 0); chk("R6 act on open", perm_act, 0); tick();
    drive(0, 0, 0, 0, 0); chk("R4 rd blocked t+2", perm_rd, 0); tick();
    drive(0, 0, 0, 0, 0); chk("R4 rd allowed t+3", perm_rd, 1); tick();

    // R2 / R7 (SDR, latency 3)
    cmd(1, 0);
    drive(0, 0, 0, 0, 0); chk("R2 wr blocked t+1", perm_wr, 0); chk("R7 no strobe t+1", cap_strobe, 0); tick();
    drive(0, 0, 0, 0, 0); chk("R2 wr blocked t+2", perm_wr, 0); chk("R7 no strobe t+2", cap_strobe, 0); tick();
    drive(0, 0, 0, 0, 0); chk("R2 wr allowed t+3", perm_wr, 1); chk("R7 strobe t+3", cap_strobe, 1);
    chk("R7 sdr half", cap_half, 0); tick();

    // R3
    cmd(2, 0);
    for (int k = 1; k <= 3; k++) begin
      drive(0, 0, 0, 0, 0); chk("R3 pre blocked", perm_pre, 0); tick();
    end
    drive(0, 0, 0, 0, 0); chk("R3 pre allowed t+4", perm_pre, 1); tick();

    // R5 precharge then refresh
    cmd(3, 0);
    drive(0, 0, 0, 0, 0); chk("R5 act blocked t+1", perm_act, 0); chk("R5 ref blocked", perm_ref, 0); tick();
    drive(0, 0, 0, 0, 0); chk("R5 act blocked t+2", perm_act, 0); tick();
    drive(0, 0, 0, 0, 0); chk("R5 act allowed t+3", perm_act, 1); tick();
    cmd(4, 0);
    drive(0, 0, 0, 0, 0); chk("R5 act blocked after ref", perm_act, 0); tick();
    drive(0, 0, 0, 0, 0); chk("R5 act allowed after ref", perm_act, 1); tick();

    // R9 read to closed bank
    cmd(1, 1);
    drive(0, 0, 0, 0, 0); chk("R9 count after violation", viol_count, 1); chk("R9 sticky set", viol_sticky, 1); tick();
    idle(6);

    // R8 and DDR strobe
    wb = mkword(3, 4, 7, 2, 3, 2);
    drive(0, 0, 0, 1, wb); tick();
    drive(0, 0, 0, 0, 0); chk("R8 err sdr code7", cfg_err, 1); tick();
    want_ddr = 1;
    drive(0, 0, 0, 0, 0); chk("R8 no err ddr", cfg_err, 0); tick();
    cmd(0, 0); idle(3);
    cmd(1, 0);
    idle(1);
    drive(0, 0, 0, 0, 0); chk("R7 ddr no strobe t+2", cap_strobe, 0); tick();
    drive(0, 0, 0, 0, 0); chk("R7 ddr strobe t+3", cap_strobe, 1); chk("R7 ddr half", cap_half, 1); tick();
    idle(4);

    // R10 load while busy is dropped, load while idle taken
    cmd(0, 2);
    drive(0, 0, 0, 1, mkword(3, 4, 7, 0, 3, 2)); tick();
    idle(5); cmd(3, 2); idle(5);
    cmd(0, 2);
    drive(0, 0, 2, 0, 0); chk("R10 busy load dropped", perm_rd, 0); tick();
    idle(5);
    drive(0, 0, 0, 1, mkword(3, 4, 7, 0, 3, 2)); tick();
    idle(1);
    cmd(0, 3);
    drive(0, 0, 3, 0, 0); chk("R10 idle load taken", perm_rd, 1); tick();
    idle(6);

    // random phases: SDR then DDR
    for (int ph = 0; ph < 2; ph++) begin
      want_ddr = (ph == 1);
      for (int i = 0; i < 3000; i++) begin
        int op, b;
        bit forced, v, cw;
        op = int'($urandom % 6);
        b  = int'($urandom % 4);
        forced = ($urandom % 10) < 2;
        v  = forced || (op < 5 && permit(op, b));
        cw = ($urandom % 40) == 0;
        drive(v, op, b, cw, $urandom);
        tick();
      end
      idle(20);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule